// File: doc/BRIEF.md
# Low-Power Sleep and Wakeup Controller

This block sits beside a small 8-bit processor core and owns its two clock gates. One enable feeds the oscillator and processor clocks. The other feeds the timer clock domain. The core raises a one-cycle deep-sleep (STOP) or light-sleep (WAIT) request. The controller then drops the matching enables and watches eight interrupt sources until one of them is allowed to end that sleep state.

Deep sleep halts both clock domains, and only four sources can end it: the external pin interrupt, the periodic interrupt, the keyboard interrupt and the low-voltage interrupt. Light sleep halts only the processor clocks, so the timers keep counting, and any of the eight sources can end it.

On wakeup, and once after every reset, the block issues a one-cycle pulse with the 16-bit address of the vector the core must fetch next. The block also holds the interrupt-mask bit. Reset forces that bit to 1, and every wakeup sets it to 1 again.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, the block is in the run state: `cpu_clk_en`=1, `tmr_clk_en`=1, `imask`=1, `vec_addr`=0xFFFE and `vec_vld`=0. This takes effect asynchronously. At the first clock edge after release, `vec_vld` pulses for one cycle with `vec_addr`=0xFFFE.
- R2: A `stop_req` seen in the run state drops both `cpu_clk_en` and `tmr_clk_en` from the next cycle. Both stay low until a wake event or reset.
- R3: A `wait_req` seen in the run state drops only `cpu_clk_en`. `tmr_clk_en` stays high throughout. If both requests arrive together, STOP wins.
- R4: In STOP, only source bits 0 (external pin), 3 (periodic), 6 (keyboard) and 7 (low voltage) can wake the block. Bits 1, 2, 4 and 5 have no effect.
- R5: In WAIT, any of the eight source bits can wake the block: 0 external pin, 1 core timer, 2 16-bit timer, 3 periodic, 4 SPI, 5 SCI, 6 keyboard, 7 low voltage.
- R6: A source counts only when both its `irq_req` and its `irq_en` bit are 1. Bits 0 to 6 also need `imask`=0. Bit 7 (low voltage) ignores `imask`.
- R7: A wake event seen at a clock edge raises both clock enables at that edge. At the same edge, `vec_vld` pulses for exactly one cycle and `imask` becomes 1.
- R8: When several eligible sources are present at once, the lowest bit index wins.
- R9: The vector addresses are:
  - bit 0: 0xFFFA
  - bits 1 and 3 (shared): 0xFFF8
  - bit 2: 0xFFF6
  - bit 4: 0xFFF4
  - bit 5: 0xFFF2
  - bit 6: 0xFFF0
  - bit 7: 0xFFEE
- R10: `imask_clr` clears `imask` at the next edge and `imask_set` sets it. If both are high, set wins.
- R11: A `stop_req` or `wait_req` that arrives while the block is already asleep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle deep-sleep request from the core |
| wait_req | input | 1 | One-cycle light-sleep request from the core |
| imask_set | input | 1 | Sets the interrupt-mask bit |
| imask_clr | input | 1 | Clears the interrupt-mask bit |
| irq_req | input | 8 | Per-source interrupt request flags |
| irq_en | input | 8 | Per-source interrupt enables |
| cpu_clk_en | output | 1 | Enable for the oscillator and processor clocks |
| tmr_clk_en | output | 1 | Enable for the timer clock domain |
| imask | output | 1 | Interrupt-mask bit |
| vec_vld | output | 1 | One-cycle pulse marking a vector fetch |
| vec_addr | output | 16 | Address of the vector to fetch |

## Verification
The assertions check four rules on every cycle:
- Light sleep never turns the timer clock off.
- Deep sleep and light sleep hold steady while no eligible source is present, including while the mask is set.
- Every rise of the processor clock enable comes with a vector pulse, and that pulse lasts one cycle.
- An enabled, unmasked external pin request always produces address 0xFFFA.

The remaining rules can only be shown by the bench's scenarios, which compare each issued vector against a queue of expected addresses:
- the exact vector for each source;
- the shared vector for bits 1 and 3;
- the outcome when several sources arrive at once;
- that sleep requests made while asleep are ignored;
- that the mask set/clear inputs work as stated.

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl #(
  parameter int              NSRC      = 8,
  parameter logic [NSRC-1:0] STOP_SRCS = 8'hC9,
  parameter logic [NSRC-1:0] NMI_SRCS  = 8'h80,
  parameter logic [15:0]     RESET_VEC = 16'hFFFE,
  parameter logic [NSRC*16-1:0] VEC_TABLE = {16'hFFEE, 16'hFFF0, 16'hFFF2, 16'hFFF4,
                                            16'hFFF8, 16'hFFF6, 16'hFFF8, 16'hFFFA}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_req,
  input  logic            wait_req,
  input  logic            imask_set,
  input  logic            imask_clr,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  output logic            cpu_clk_en,
  output logic            tmr_clk_en,
  output logic            imask,
  output logic            vec_vld,
  output logic [15:0]     vec_addr
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  typedef enum logic [1:0] {PS_RUN, PS_WAIT, PS_STOP} pstate_t;

  pstate_t         state;
  logic            rst_pend;
  logic [NSRC-1:0] scope, elig;
  logic [IW-1:0]   win;
  logic            any_wake;

  assign scope = (state == PS_STOP) ? STOP_SRCS :
                 (state == PS_WAIT) ? {NSRC{1'b1}} : {NSRC{1'b0}};
  assign elig  = irq_req & irq_en & scope & (imask ? NMI_SRCS : {NSRC{1'b1}});
  assign any_wake = |elig;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) win = i[IW-1:0];
  end

  assign cpu_clk_en = (state == PS_RUN);
  assign tmr_clk_en = (state != PS_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_RUN;
      imask    <= 1'b1;
      rst_pend <= 1'b1;
      vec_vld  <= 1'b0;
      vec_addr <= RESET_VEC;
    end else begin
      vec_vld <= 1'b0;
      if (imask_set)      imask <= 1'b1;
      else if (imask_clr) imask <= 1'b0;
      if (rst_pend) begin
        rst_pend <= 1'b0;
        vec_vld  <= 1'b1;
        vec_addr <= RESET_VEC;
      end else if (state != PS_RUN) begin
        if (any_wake) begin
          state    <= PS_RUN;
          vec_vld  <= 1'b1;
          vec_addr <= VEC_TABLE[32'(win)*16 +: 16];
          imask    <= 1'b1;
        end
      end else if (stop_req) begin
        state <= PS_STOP;
      end else if (wait_req) begin
        state <= PS_WAIT;
      end
    end
  end
endmodule

// File: rtl/lpm_wake_ctrl_chk.sv
module lpm_wake_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  irq_req,
  input logic [7:0]  irq_en,
  input logic        cpu_clk_en,
  input logic        tmr_clk_en,
  input logic        imask,
  input logic        vec_vld,
  input logic [15:0] vec_addr
);
  // R3
  wait_keeps_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clk_en && !cpu_clk_en) |=> tmr_clk_en);

  // R4
  stop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_clk_en && ((irq_req & irq_en & 8'hC9) == 8'h00)) |=> !tmr_clk_en);

  // R6
  masked_sleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && imask && !(irq_req[7] && irq_en[7])) |=> !cpu_clk_en);

  // R7
  wake_has_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> vec_vld);

  // R7
  vec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |=> !vec_vld);

  // R8
  pin_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) && $past(irq_req[0] && irq_en[0] && !imask)) |-> (vec_addr == 16'hFFFA));
endmodule

bind lpm_wake_ctrl lpm_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
  .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en), .imask(imask),
  .vec_vld(vec_vld), .vec_addr(vec_addr)
);

// File: tb/lpm_wake_ctrl_bench.sv
module lpm_wake_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop_req = 1'b0, wait_req = 1'b0, imask_set = 1'b0, imask_clr = 1'b0;
  logic [7:0]  irq_req = '0, irq_en = '0;
  logic        cpu_clk_en, tmr_clk_en, imask, vec_vld;
  logic [15:0] vec_addr;

  int total = 0, bad = 0;
  logic [15:0] expq[$];
  bit done = 0;

  always #4 clk = ~clk;

  lpm_wake_ctrl u_lpm_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .imask_set(imask_set), .imask_clr(imask_clr), .irq_req(irq_req), .irq_en(irq_en),
    .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en), .imask(imask),
    .vec_vld(vec_vld), .vec_addr(vec_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every vector pulse must match the oldest expected item
  always @(negedge clk) begin
    if (rst_n && vec_vld) begin
      if (expq.size() == 0) chk(1'b0, "R7 unexpected vector", int'(vec_addr), 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(vec_addr == e, "R9 vector address", int'(vec_addr), int'(e));
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic clr_mask();
    imask_clr = 1'b1; tick(); imask_clr = 1'b0;
    chk(imask == 1'b0, "R10 mask clear", int'(imask), 0);
  endtask

  task automatic sleep(input bit deep);
    if (deep) stop_req = 1'b1; else wait_req = 1'b1;
    tick(); stop_req = 1'b0; wait_req = 1'b0;
    chk(cpu_clk_en == 1'b0, deep ? "R2 cpu gated" : "R3 cpu gated", int'(cpu_clk_en), 0);
    chk(tmr_clk_en == !deep, deep ? "R2 timer gated" : "R3 timer kept", int'(tmr_clk_en), int'(!deep));
  endtask

  task automatic no_wake(input logic [7:0] r, input logic [7:0] en, input bit deep, input string req);
    irq_req = r; irq_en = en; tick(); tick();
    chk(cpu_clk_en == 1'b0 && tmr_clk_en == !deep, req, int'({cpu_clk_en, tmr_clk_en}), int'({1'b0, !deep}));
    irq_req = '0; irq_en = '0;
  endtask

  task automatic wake(input logic [7:0] r, input logic [7:0] en, input logic [15:0] exp, input string req);
    expq.push_back(exp);
    irq_req = r; irq_en = en; tick();
    chk(cpu_clk_en && tmr_clk_en, {req, " enables back"}, int'({cpu_clk_en, tmr_clk_en}), 3);
    chk(imask == 1'b1, "R7 mask set on wake", int'(imask), 1);
    irq_req = '0; irq_en = '0; tick();
    chk(expq.size() == 0, {req, " vector seen"}, expq.size(), 0);
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] vtab [8];
    vtab = '{16'hFFFA, 16'hFFF8, 16'hFFF6, 16'hFFF8, 16'hFFF4, 16'hFFF2, 16'hFFF0, 16'hFFEE};
    tick(); tick();
    // R1 reset state
    chk(cpu_clk_en && tmr_clk_en, "R1 enables in reset", int'({cpu_clk_en, tmr_clk_en}), 3);
    chk(imask == 1'b1, "R1 mask in reset", int'(imask), 1);
    chk(vec_addr == 16'hFFFE && !vec_vld, "R1 reset vector", int'(vec_addr), 16'hFFFE);
    expq.push_back(16'hFFFE);
    rst_n = 1'b1; tick(); tick();
    chk(expq.size() == 0, "R1 reset pulse", expq.size(), 0);

    // R10 set wins over clear
    imask_set = 1'b1; imask_clr = 1'b1; tick(); imask_set = 1'b0; imask_clr = 1'b0;
    chk(imask == 1'b1, "R10 set wins", int'(imask), 1);
    clr_mask();

    // R6 disabled source does not wake; R5 SPI wakes WAIT
    sleep(1'b0);
    no_wake(8'h10, 8'h00, 1'b0, "R6 disabled source ignored");
    wake(8'h10, 8'h10, 16'hFFF4, "R5 spi wake");

    // R2 STOP ignores timer and serial sources (R4), keyboard wakes
    clr_mask();
    sleep(1'b1);
    no_wake(8'h36, 8'h36, 1'b1, "R4 stop ignores non-stop sources");
    wake(8'h40, 8'h40, 16'hFFF0, "R4 keyboard wake");

    // R6 masked: pin ignored, low voltage still wakes
    sleep(1'b1);
    no_wake(8'h01, 8'h01, 1'b1, "R6 mask blocks pin");
    wake(8'h81, 8'h81, 16'hFFEE, "R6 low voltage ignores mask");

    // R8 priority
    clr_mask(); sleep(1'b0);
    wake(8'h26, 8'hFF, 16'hFFF8, "R8 core timer over others");
    clr_mask(); sleep(1'b0);
    wake(8'h48, 8'hFF, 16'hFFF8, "R8 periodic over keyboard");
    clr_mask(); sleep(1'b1);
    wake(8'h81, 8'hFF, 16'hFFFA, "R8 pin over low voltage");

    // R3 stop wins over wait; R11 requests while asleep ignored
    clr_mask();
    stop_req = 1'b1; wait_req = 1'b1; tick(); stop_req = 1'b0; wait_req = 1'b0;
    chk(!tmr_clk_en && !cpu_clk_en, "R3 stop wins", int'({cpu_clk_en, tmr_clk_en}), 0);
    wait_req = 1'b1; tick(); wait_req = 1'b0; tick();
    chk(!tmr_clk_en, "R11 wait ignored in stop", int'(tmr_clk_en), 0);
    wake(8'h08, 8'h08, 16'hFFF8, "R4 periodic wake");
    clr_mask(); sleep(1'b0);
    stop_req = 1'b1; tick(); stop_req = 1'b0; tick();
    chk(tmr_clk_en && !cpu_clk_en, "R11 stop ignored in wait", int'({cpu_clk_en, tmr_clk_en}), 1);
    wake(8'h01, 8'h01, 16'hFFFA, "R5 pin wake");

    // R9 every source from WAIT
    for (int i = 0; i < 8; i++) begin
      clr_mask(); sleep(1'b0);
      wake(8'h01 << i, 8'h01 << i, vtab[i], "R9 per-source vector");
    end

    tick(); tick();
    chk(expq.size() == 0, "R7 queue drained", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule